// File: doc/BRIEF.md
# Conversion Result Byte Pair with Coherent Read Lock

This block keeps the latest 10-bit result from a converter and shows it to a processor as two 8-bit read-only locations on a small bus read port: a low byte at offset 0x04 and a high byte at offset 0x05. A control input picks how the 10 bits are spread across the two bytes. In right alignment the result sits at the bottom of the 16-bit pair. In left alignment it sits at the top, so the high byte alone is an 8-bit result.

A low-byte read locks the held result. Conversions that finish while the lock is set are discarded. A later high-byte read releases the lock, so the two bytes of one full read always belong to the same conversion. Read data is combinational: it is valid in the same cycle as the read strobe. The held value and the lock change only on a clock edge.

Top module: `adcres_regpair`

## Requirements
- R1: After reset, the held result is zero, both bytes read 0x00, and the lock is clear.
- R2: With `adj_left` = 0, offset 0x04 returns result bits 7..0. Offset 0x05 returns bits 9..8 in its bits 1..0, and its bits 7..2 read zero.
- R3: With `adj_left` = 1, offset 0x05 returns result bits 9..2. Offset 0x04 returns bits 1..0 in its bits 7..6, and its bits 5..0 read zero.
- R4: While unlocked, a `conv_valid` pulse stores `conv_result`, and a read in the next cycle returns it.
- R5: A read strobe at offset 0x04 sets the lock. While the lock is set, `conv_valid` pulses are discarded and the held value does not change.
- R6: A read strobe at offset 0x05 clears the lock, and the next conversion is stored.
- R7: A high-byte read with the lock clear has no effect except returning data. A conversion that follows it is stored.
- R8: When a conversion and a low-byte read happen in the same cycle, the read returns the old value, the conversion is discarded, and the lock holds the old value.
- R9: When a conversion and a lock-releasing high-byte read happen in the same cycle, the read returns the old value and the conversion is stored.
- R10: Changing `adj_left` re-formats the held result on the next read, with no new conversion.
- R11: With `bus_rd` low, or with any offset other than 0x04 or 0x05, `bus_rdata` is 0x00 and the lock does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Read offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid in the cycle of the strobe |
| conv_valid | input | 1 | Conversion-complete pulse |
| conv_result | input | 10 | Conversion value, qualified by conv_valid |
| adj_left | input | 1 | 1 = left alignment, 0 = right alignment |

## Verification
Two events can land in the same cycle: a finished conversion and a processor read that changes the lock. The bench creates this by pulsing `conv_valid` in the same cycle as a low-byte strobe, and again in the same cycle as a high-byte strobe that ends a lock. In both cases the byte returned must be the old value. The bench then reads both bytes. The result must still be the old value after the low-byte case, and must be the new value after the high-byte case.

// File: rtl/adcres_pkg.sv
package adcres_pkg;

   // Which byte of the pair a bus access selects
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_LO   = 2'd1,
      SEL_HI   = 2'd2
   } rsel_e;

   localparam int unsigned DEF_RES_W  = 10;
   localparam int unsigned DEF_BYTE_W = 8;
   localparam int unsigned DEF_ADDR_W = 8;

endpackage

// File: rtl/adcres_rdport.sv
module adcres_rdport
   import adcres_pkg::*;
#(
   parameter int unsigned BYTE_W  = DEF_BYTE_W,
   parameter int unsigned ADDR_W  = DEF_ADDR_W,
   parameter logic [ADDR_W-1:0] LO_OFS = ADDR_W'(4),
   parameter logic [ADDR_W-1:0] HI_OFS = ADDR_W'(5)
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic [BYTE_W-1:0] lo_byte,
   input  logic [BYTE_W-1:0] hi_byte,
   output rsel_e             sel,
   output logic [BYTE_W-1:0] bus_rdata
);

   if (LO_OFS == HI_OFS) begin : g_ofs_chk
      $error("adcres_rdport: the two byte offsets must differ");
   end

   always_comb begin
      sel = SEL_NONE;
      if (bus_rd) begin
         if (bus_addr == LO_OFS)      sel = SEL_LO;
         else if (bus_addr == HI_OFS) sel = SEL_HI;
      end
   end

   always_comb begin
      unique case (sel)
         SEL_LO:  bus_rdata = lo_byte;
         SEL_HI:  bus_rdata = hi_byte;
         default: bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/adcres_format.sv
module adcres_format
   import adcres_pkg::*;
#(
   parameter int unsigned RES_W  = DEF_RES_W,
   parameter int unsigned BYTE_W = DEF_BYTE_W
) (
   input  logic [RES_W-1:0]  held,
   input  logic              adj_left,
   output logic [BYTE_W-1:0] lo_byte,
   output logic [BYTE_W-1:0] hi_byte
);

   localparam int unsigned PAIR_W = 2 * BYTE_W;
   localparam int unsigned PAD_W  = PAIR_W - RES_W;

   logic [PAIR_W-1:0] pair_right;
   logic [PAIR_W-1:0] pair_left;
   logic [PAIR_W-1:0] pair_sel;

   // A result that fills the whole pair needs no padding and only one layout
   if (PAD_W == 0) begin : g_full
      assign pair_right = held;
      assign pair_left  = held;
   end else begin : g_padded
      assign pair_right = {{PAD_W{1'b0}}, held};
      assign pair_left  = {held, {PAD_W{1'b0}}};
   end

   assign pair_sel = adj_left ? pair_left : pair_right;
   assign lo_byte  = pair_sel[BYTE_W-1:0];
   assign hi_byte  = pair_sel[PAIR_W-1:BYTE_W];

endmodule

// File: rtl/adcres_hold.sv
module adcres_hold
   import adcres_pkg::*;
#(
   parameter int unsigned RES_W = DEF_RES_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_valid,
   input  logic [RES_W-1:0] conv_result,
   input  rsel_e            sel,
   output logic [RES_W-1:0] held,
   output logic             locked
);

   logic lo_hit, hi_hit, take;

   assign lo_hit = (sel == SEL_LO);
   assign hi_hit = (sel == SEL_HI);
   // A high read ends the lock at this edge, so a result arriving with it is
   // stored. A low read freezes the current value, so a result arriving with
   // it is discarded.
   assign take   = conv_valid && !lo_hit && (!locked || hi_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held   <= '0;
         locked <= 1'b0;
      end else begin
         if (take)        held <= conv_result;
         if (lo_hit)      locked <= 1'b1;
         else if (hi_hit) locked <= 1'b0;
      end
   end

   AST_LOCK_ON_LO: assert property (@(posedge clk) disable iff (!rst_n)
      lo_hit |=> locked); // R5
   AST_DROP_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !hi_hit) |=> $stable(held)); // R5
   AST_RELEASE_ON_HI: assert property (@(posedge clk) disable iff (!rst_n)
      hi_hit |=> !locked); // R6
   AST_STORE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_valid && !locked && !lo_hit) |=> (held == $past(conv_result))); // R4
   AST_SAME_CYCLE_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_valid && lo_hit) |=> ($stable(held) && locked)); // R8
   AST_SAME_CYCLE_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_valid && hi_hit && locked) |=> (held == $past(conv_result))); // R9
   AST_IDLE_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE) |=> (locked == $past(locked))); // R11

endmodule

// File: rtl/adcres_regpair.sv
module adcres_regpair
   import adcres_pkg::*;
#(
   parameter int unsigned RES_W  = DEF_RES_W,
   parameter int unsigned BYTE_W = DEF_BYTE_W,
   parameter int unsigned ADDR_W = DEF_ADDR_W,
   parameter logic [ADDR_W-1:0] LO_OFS = ADDR_W'(4),
   parameter logic [ADDR_W-1:0] HI_OFS = ADDR_W'(5)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              conv_valid,
   input  logic [RES_W-1:0]  conv_result,
   input  logic              adj_left
);

   localparam int unsigned PAD_W = 2 * BYTE_W - RES_W;

   if (RES_W <= BYTE_W || RES_W > 2 * BYTE_W) begin : g_width_chk
      $error("adcres_regpair: RES_W must lie in (BYTE_W, 2*BYTE_W]");
   end

   logic [RES_W-1:0]  held;
   logic              locked;
   logic [BYTE_W-1:0] lo_byte, hi_byte;
   rsel_e             sel;

   adcres_rdport #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS))
   u_rdport (
      .bus_addr (bus_addr),
      .bus_rd   (bus_rd),
      .lo_byte  (lo_byte),
      .hi_byte  (hi_byte),
      .sel      (sel),
      .bus_rdata(bus_rdata)
   );

   adcres_hold #(.RES_W(RES_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .conv_valid (conv_valid),
      .conv_result(conv_result),
      .sel        (sel),
      .held       (held),
      .locked     (locked)
   );

   adcres_format #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_format (
      .held    (held),
      .adj_left(adj_left),
      .lo_byte (lo_byte),
      .hi_byte (hi_byte)
   );

   if (PAD_W > 0) begin : g_pad_checks
      AST_RIGHT_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && bus_addr == HI_OFS && !adj_left)
            |-> (bus_rdata[BYTE_W-1:BYTE_W-PAD_W] == '0)); // R2
      AST_LEFT_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && bus_addr == LO_OFS && adj_left)
            |-> (bus_rdata[PAD_W-1:0] == '0)); // R3
   end

   AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd || (bus_addr != LO_OFS && bus_addr != HI_OFS)) |-> (bus_rdata == '0)); // R11
   AST_LOCK_STATE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(locked)); // R1

endmodule

// File: tb/tb_adcres_regpair.sv
module tb_adcres_regpair;

   localparam int CLK_P = 10;
   localparam logic [7:0] LO = 8'h04;
   localparam logic [7:0] HI = 8'h05;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic       conv_valid = 1'b0;
   logic [9:0] conv_result = '0;
   logic       adj_left = 1'b0;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   adcres_regpair dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_rdata(bus_rdata), .conv_valid(conv_valid),
      .conv_result(conv_result), .adj_left(adj_left)
   );

   // One clock: drive after the falling edge, sample before the rising edge
   task automatic step(input logic rd, input logic [7:0] a, input logic cv,
                       input logic [9:0] cd, output logic [7:0] q);
      @(negedge clk);
      bus_rd = rd; bus_addr = a; conv_valid = cv; conv_result = cd;
      #(CLK_P/4);
      q = bus_rdata;
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic conv(input logic [9:0] v);
      logic [7:0] q;
      step(1'b0, 8'h00, 1'b1, v, q);
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] q);
      step(1'b1, a, 1'b0, 10'h0, q);
   endtask

   task automatic t_reset;
      logic [7:0] q;
      rd(LO, q); check("R1 low byte", q, 8'h00);
      rd(HI, q); check("R1 high byte", q, 8'h00);
   endtask

   task automatic t_right;
      logic [7:0] q;
      adj_left = 1'b0;
      conv(10'h2A5);
      rd(LO, q); check("R2/R4 right low", q, 8'hA5);
      rd(HI, q); check("R2 right high", q, 8'h02);
   endtask

   task automatic t_left_reformat;
      logic [7:0] q;
      adj_left = 1'b1;
      rd(LO, q); check("R3/R10 left low", q, 8'h40);
      rd(HI, q); check("R3/R10 left high", q, 8'hA9);
   endtask

   task automatic t_lock;
      logic [7:0] q;
      adj_left = 1'b0;
      conv(10'h155);
      rd(LO, q); check("R5 low before drop", q, 8'h55);
      conv(10'h3FF);
      rd(HI, q); check("R5 high keeps locked value", q, 8'h01);
      conv(10'h3FF);
      rd(LO, q); check("R6 low after release", q, 8'hFF);
      rd(HI, q); check("R6 high after release", q, 8'h03);
   endtask

   task automatic t_hi_only;
      logic [7:0] q;
      adj_left = 1'b1;
      conv(10'h3C0);
      rd(HI, q); check("R7 high only", q, 8'hF0);
      conv(10'h081);
      rd(HI, q); check("R7 no lock left behind", q, 8'h20);
   endtask

   task automatic t_same_lo;
      logic [7:0] q;
      adj_left = 1'b0;
      step(1'b1, LO, 1'b1, 10'h123, q); check("R8 read returns old", q, 8'h81);
      conv(10'h1F0);
      rd(HI, q); check("R8 high of old value", q, 8'h00);
      rd(LO, q); check("R8 old value kept", q, 8'h81);
      rd(HI, q);
   endtask

   task automatic t_same_hi;
      logic [7:0] q;
      adj_left = 1'b0;
      rd(LO, q); check("R9 lock on old", q, 8'h81);
      step(1'b1, HI, 1'b1, 10'h2F0, q); check("R9 high returns old", q, 8'h00);
      rd(LO, q); check("R9 new low stored", q, 8'hF0);
      rd(HI, q); check("R9 new high stored", q, 8'h02);
   endtask

   task automatic t_quiet;
      logic [7:0] q;
      step(1'b1, 8'h06, 1'b0, 10'h0, q); check("R11 unmapped offset", q, 8'h00);
      step(1'b0, LO, 1'b0, 10'h0, q); check("R11 no strobe", q, 8'h00);
      conv(10'h0AA);
      rd(LO, q); check("R11 no lock from idle", q, 8'hAA);
      rd(HI, q); check("R11 high", q, 8'h00);
   endtask

   initial begin : wdog
      repeat (5000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_right();
      t_left_reformat();
      t_lock();
      t_hi_only();
      t_same_lo();
      t_same_hi();
      t_quiet();
      @(negedge clk) bus_rd = 1'b0;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule